// File: doc/BRIEF.md
# Oversampled Threshold Serial Byte Decoder

This block turns a stream of oversampled line samples into bytes. Each sample arrives as a raw unsigned conversion word with a valid strobe. The block drops the low bits of the word and compares what is left against a threshold supplied from outside. It looks for a start mark by majority vote over a sliding window. From that mark it counts samples to eight bit cells with slightly uneven spacing, decides each cell by a small majority vote, and assembles a byte. A frame carries two bytes. Between the two bytes there is a fixed gap of samples before the second start search begins.

A pulse on the frame-start input restarts the decoder at the search for the first byte. Each decoded byte is reported with a one-cycle pulse and its index in the frame. If a start search runs past its limit, the block reports an error code for that byte position, and the frame ends there. The threshold is computed elsewhere and applied here as a plain input.

Top module: `ovs_byte_decoder`

## Requirements
- R1: The block discards the low SHIFT (3) bits of a raw sample, leaving a level. A sample counts as high only when that level is strictly greater than `threshold`; a level equal to the threshold counts as low.
- R2: A start is recognised when at least WIN_MIN (4) of WIN (5) consecutive samples are high. While no start is found, the window moves forward by one sample, so a window with only 3 highs is passed over.
- R3: The window may be advanced SEARCH_LIMIT (400) times, which means the windows starting at search offsets 0 to 400 are all tried. If the last of these also fails, `err_valid` pulses for one cycle and the search ends. `err_code` is 0x11 for byte index 0 and 0x22 for byte index 1. A start in the window at offset 400 is still accepted.
- R4: Counting from the first sample of the start window as offset 0, bit k is voted over the three samples that begin at offsets 23, 39, 56, 72, 88, 105, 121 and 137 (k = 0 to 7).
- R5: Each bit takes a 2-of-3 vote over its three samples. A high majority decodes as 0 and a low majority decodes as 1.
- R6: The first bit voted becomes byte bit 0 (LSB), and the eighth bit voted becomes bit 7.
- R7: The second byte's search window starts at offset 187, counted from the first byte's start window. Samples in the gap before that point have no effect.
- R8: `byte_valid` pulses for one cycle, in the cycle after the edge that takes the byte's last voted sample. It carries `byte_idx` (0, then 1) and `byte_data`. After two bytes, or after an error, no further output appears until the next frame start. All outputs are 0 after reset.
- R9: `frame_start` restarts the decoder at the first byte's search from any state. A sample presented in the same cycle as `frame_start` is ignored.
- R10: Cycles with `smp_valid` low are ignored: they move no sample position and leave the decoded result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Restart the decoder at the search for byte 0 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | RAW_W (12) | Raw conversion word |
| threshold | input | RAW_W-SHIFT (9) | Level compare threshold |
| byte_valid | output | 1 | One-cycle pulse for a decoded byte |
| byte_idx | output | IDX_W (1) | Position of the byte in the frame |
| byte_data | output | 8 | Decoded byte |
| err_valid | output | 1 | One-cycle pulse when a start search times out |
| err_code | output | 8 | Error code for the byte position that failed |

## Verification
The bench builds the block with its default parameters: a 5-sample window with a 4-high rule, a 2-of-3 bit vote, a search limit of 400, a lead of 7, a 16/16/17 spacing, a gap of 50 and two bytes per frame. With these values a full timeout takes only 405 samples, so the bench reaches the exact edge of the limit (a start at offset 400) and errors on both byte positions. The high and low raw words are chosen one count either side of the shifted threshold, which puts the strict compare on every sample. Each bit triple has its odd sample placed at alternating ends, so an offset that is off by one sample gives a wrong byte.

// File: rtl/ovsd_pkg.sv
package ovsd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_BITS   = 2'd2,
      ST_GAP    = 2'd3
   } ovsd_state_e;

   // Offset of the first voted sample of bit k, counted from the first
   // sample of the start window. Every LONG_EVERY-th spacing is one longer.
   function automatic int bit_start(input int k, input int lead,
                                    input int spacing, input int long_every);
      int acc;
      acc = lead;
      for (int j = 0; j <= k; j++) begin
         acc += spacing;
         if ((j % long_every) == (long_every - 1))
            acc += 1;
      end
      return acc;
   endfunction

endpackage

// File: rtl/ovsd_slicer.sv
module ovsd_slicer #(
   parameter int RAW_W = 12,
   parameter int SHIFT = 3,
   localparam int LVL_W = RAW_W - SHIFT
) (
   input  logic [RAW_W-1:0] raw,
   input  logic [LVL_W-1:0] thr,
   output logic             hi
);

   logic [LVL_W-1:0] level;

   generate
      if (SHIFT > 0) begin : g_shift
         assign level = raw[RAW_W-1:SHIFT];
      end else begin : g_noshift
         assign level = raw;
      end
   endgenerate

   assign hi = (level > thr);

endmodule

// File: rtl/ovsd_window.sv
module ovsd_window #(
   parameter int WIN   = 5,
   parameter int VOTE  = 3,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             hi_in,
   output logic [CNT_W-1:0] win_cnt,
   output logic [CNT_W-1:0] tail_cnt
);

   // hist[0] is the most recent stored flag
   logic [WIN-2:0] hist;
   logic [WIN-1:0] full;

   assign full = {hist, hi_in};

   always_comb begin
      win_cnt = '0;
      for (int i = 0; i < WIN; i++)
         win_cnt += CNT_W'(full[i]);
   end

   always_comb begin
      tail_cnt = '0;
      for (int i = 0; i < VOTE; i++)
         tail_cnt += CNT_W'(full[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hist <= '0;
      else if (shift_en)
         hist <= full[WIN-2:0];
   end

endmodule

// File: rtl/ovsd_seq.sv
module ovsd_seq #(
   parameter int WIN          = 5,
   parameter int WIN_MIN      = 4,
   parameter int VOTE         = 3,
   parameter int VOTE_MIN     = 2,
   parameter int SEARCH_LIMIT = 400,
   parameter int LEAD         = 7,
   parameter int BIT_SP       = 16,
   parameter int LONG_EVERY   = 3,
   parameter int GAP          = 50,
   parameter int NBYTES       = 2,
   parameter int ERR_STEP     = 8'h11,
   parameter bit INVERT       = 1'b1,
   parameter int IDX_W        = 1,
   parameter int CNT_W        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             sample_en,
   input  logic [CNT_W-1:0] win_cnt,
   input  logic [CNT_W-1:0] tail_cnt,
   output logic             byte_valid,
   output logic [IDX_W-1:0] byte_idx,
   output logic [7:0]       byte_data,
   output logic             err_valid,
   output logic [7:0]       err_code
);
   import ovsd_pkg::*;

   localparam int NBITS   = 8;
   localparam int T_LAST  = bit_start(NBITS - 1, LEAD, BIT_SP, LONG_EVERY);
   localparam int GAP_END = T_LAST + GAP - 1;
   localparam int POS_W   = $clog2(GAP_END + 1);
   localparam int ADV_W   = $clog2(SEARCH_LIMIT + 1);
   localparam int FILL_W  = (WIN > 2) ? $clog2(WIN) : 1;

   ovsd_state_e        st;
   logic [POS_W-1:0]   pos;
   logic [ADV_W-1:0]   adv;
   logic [FILL_W-1:0]  fill;
   logic [2:0]         bitn;
   logic [IDX_W-1:0]   idx;
   logic [7:0]         asm_q;
   logic [7:0]         asm_nx;
   logic [POS_W-1:0]   pos_nx;
   logic [POS_W-1:0]   last_pos [NBITS];
   logic               vote_hi;
   logic               bit_val;
   logic               win_ok;
   logic               hit;

   // Position of the last voted sample for each bit
   generate
      for (genvar k = 0; k < NBITS; k++) begin : g_tab
         assign last_pos[k] = POS_W'(bit_start(k, LEAD, BIT_SP, LONG_EVERY) + VOTE - 1);
      end
   endgenerate

   assign vote_hi = (int'(tail_cnt) >= VOTE_MIN);
   assign win_ok  = (int'(win_cnt) >= WIN_MIN);

   generate
      if (INVERT) begin : g_inv
         assign bit_val = ~vote_hi;
      end else begin : g_true
         assign bit_val = vote_hi;
      end
   endgenerate

   assign pos_nx = pos + 1'b1;
   assign hit    = (pos_nx == last_pos[bitn]);

   always_comb begin
      asm_nx       = asm_q;
      asm_nx[bitn] = bit_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         pos        <= '0;
         adv        <= '0;
         fill       <= '0;
         bitn       <= '0;
         idx        <= '0;
         asm_q      <= '0;
         byte_valid <= 1'b0;
         byte_idx   <= '0;
         byte_data  <= '0;
         err_valid  <= 1'b0;
         err_code   <= '0;
      end else begin
         byte_valid <= 1'b0;
         err_valid  <= 1'b0;
         if (frame_start) begin
            st   <= ST_SEARCH;
            fill <= '0;
            adv  <= '0;
            idx  <= '0;
         end else if (sample_en) begin
            unique case (st)
               ST_SEARCH: begin
                  if (int'(fill) != WIN - 1) begin
                     fill <= fill + 1'b1;
                  end else if (win_ok) begin
                     st    <= ST_BITS;
                     pos   <= POS_W'(WIN - 1);
                     bitn  <= '0;
                     asm_q <= '0;
                  end else if (int'(adv) != SEARCH_LIMIT) begin
                     adv <= adv + 1'b1;
                  end else begin
                     err_valid <= 1'b1;
                     err_code  <= 8'(ERR_STEP * (int'(idx) + 1));
                     st        <= ST_IDLE;
                  end
               end
               ST_BITS: begin
                  pos <= pos_nx;
                  if (hit) begin
                     asm_q <= asm_nx;
                     if (bitn == 3'(NBITS - 1)) begin
                        byte_valid <= 1'b1;
                        byte_data  <= asm_nx;
                        byte_idx   <= idx;
                        if (int'(idx) == NBYTES - 1) begin
                           st <= ST_IDLE;
                        end else begin
                           idx <= idx + 1'b1;
                           st  <= ST_GAP;
                        end
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end
               end
               ST_GAP: begin
                  pos <= pos_nx;
                  if (pos_nx == POS_W'(GAP_END)) begin
                     st   <= ST_SEARCH;
                     fill <= '0;
                     adv  <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R8: the byte strobe lasts a single cycle
   assert_byte_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R8: a byte and an error are never reported together
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_valid && err_valid));

   // R3: the window advance count stays within the search limit
   assert_adv_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(adv) <= SEARCH_LIMIT);

   // R10: every report follows an edge that took a valid sample
   assert_needs_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid || err_valid) |-> $past(sample_en));

   // R9: a restart cycle produces no report in the next cycle
   assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (!byte_valid && !err_valid));

   // R3: an error leaves the decoder idle
   assert_err_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (st == ST_IDLE || $past(frame_start)));

endmodule

// File: rtl/ovs_byte_decoder.sv
module ovs_byte_decoder #(
   parameter int RAW_W        = 12,
   parameter int SHIFT        = 3,
   parameter int WIN          = 5,
   parameter int WIN_MIN      = 4,
   parameter int VOTE         = 3,
   parameter int VOTE_MIN     = 2,
   parameter int SEARCH_LIMIT = 400,
   parameter int LEAD         = 7,
   parameter int BIT_SP       = 16,
   parameter int LONG_EVERY   = 3,
   parameter int GAP          = 50,
   parameter int NBYTES       = 2,
   parameter int ERR_STEP     = 8'h11,
   parameter bit INVERT       = 1'b1,
   localparam int LVL_W       = RAW_W - SHIFT,
   localparam int IDX_W       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             smp_valid,
   input  logic [RAW_W-1:0] smp_data,
   input  logic [LVL_W-1:0] threshold,
   output logic             byte_valid,
   output logic [IDX_W-1:0] byte_idx,
   output logic [7:0]       byte_data,
   output logic             err_valid,
   output logic [7:0]       err_code
);

   localparam int CNT_W = $clog2(WIN + 1);

   generate
      if (SHIFT < 0 || SHIFT >= RAW_W) begin : g_bad_shift
         $error("SHIFT must leave at least one level bit");
      end
      if (WIN < 2 || WIN_MIN < 1 || WIN_MIN > WIN) begin : g_bad_win
         $error("window size or window threshold out of range");
      end
      if (VOTE < 1 || VOTE > WIN || VOTE_MIN < 1 || VOTE_MIN > VOTE) begin : g_bad_vote
         $error("bit vote size or vote threshold out of range");
      end
      if (GAP <= VOTE) begin : g_bad_gap
         $error("GAP must exceed the bit vote length");
      end
      if (BIT_SP < VOTE || LONG_EVERY < 1 || SEARCH_LIMIT < 1 || NBYTES < 1) begin : g_bad_misc
         $error("spacing, search limit or byte count out of range");
      end
      if (LEAD + BIT_SP < WIN) begin : g_bad_lead
         $error("first bit would overlap the start window");
      end
   endgenerate

   logic             sample_en;
   logic             hi;
   logic [CNT_W-1:0] win_cnt;
   logic [CNT_W-1:0] tail_cnt;

   assign sample_en = smp_valid & ~frame_start;

   ovsd_slicer #(
      .RAW_W (RAW_W),
      .SHIFT (SHIFT)
   ) u_slicer (
      .raw (smp_data),
      .thr (threshold),
      .hi  (hi)
   );

   ovsd_window #(
      .WIN   (WIN),
      .VOTE  (VOTE),
      .CNT_W (CNT_W)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sample_en),
      .hi_in    (hi),
      .win_cnt  (win_cnt),
      .tail_cnt (tail_cnt)
   );

   ovsd_seq #(
      .WIN          (WIN),
      .WIN_MIN      (WIN_MIN),
      .VOTE         (VOTE),
      .VOTE_MIN     (VOTE_MIN),
      .SEARCH_LIMIT (SEARCH_LIMIT),
      .LEAD         (LEAD),
      .BIT_SP       (BIT_SP),
      .LONG_EVERY   (LONG_EVERY),
      .GAP          (GAP),
      .NBYTES       (NBYTES),
      .ERR_STEP     (ERR_STEP),
      .INVERT       (INVERT),
      .IDX_W        (IDX_W),
      .CNT_W        (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .sample_en   (sample_en),
      .win_cnt     (win_cnt),
      .tail_cnt    (tail_cnt),
      .byte_valid  (byte_valid),
      .byte_idx    (byte_idx),
      .byte_data   (byte_data),
      .err_valid   (err_valid),
      .err_code    (err_code)
   );

endmodule

// File: tb/sim_ovs_byte_decoder.sv
`timescale 1ns/1ps
module sim_ovs_byte_decoder;

   localparam logic [11:0] HI_RAW = 12'((100 + 1) << 3);   // level 101
   localparam logic [11:0] LO_RAW = 12'((100 << 3) | 7);   // level 100

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic [8:0]  threshold = 9'd100;
   logic        byte_valid;
   logic [0:0]  byte_idx;
   logic [7:0]  byte_data;
   logic        err_valid;
   logic [7:0]  err_code;

   always #2.5 clk = ~clk;

   ovs_byte_decoder u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .smp_valid   (smp_valid),
      .smp_data    (smp_data),
      .threshold   (threshold),
      .byte_valid  (byte_valid),
      .byte_idx    (byte_idx),
      .byte_data   (byte_data),
      .err_valid   (err_valid),
      .err_code    (err_code)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [11:0] stim [0:1023];
   int toff [8] = '{23, 39, 56, 72, 88, 105, 121, 137};

   // consumed-sample counter, restarted by frame_start
   int cnt = 0;
   always @(posedge clk) begin
      if (!rst_n || frame_start) cnt <= 0;
      else if (smp_valid)        cnt <= cnt + 1;
   end

   // event recorder
   int ev_kind [16];
   int ev_idx  [16];
   int ev_val  [16];
   int ev_cnt  [16];
   int n_ev = 0;
   bit prev_bv = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid && prev_bv) begin
            n_chk++; n_err++;
            $display("FAIL R8 byte_valid width actual=2+ expected=1");
         end
         if (byte_valid && n_ev < 16) begin
            ev_kind[n_ev] = 1; ev_idx[n_ev] = int'(byte_idx);
            ev_val[n_ev] = int'(byte_data); ev_cnt[n_ev] = cnt; n_ev++;
         end
         if (err_valid && n_ev < 16) begin
            ev_kind[n_ev] = 2; ev_idx[n_ev] = 0;
            ev_val[n_ev] = int'(err_code); ev_cnt[n_ev] = cnt; n_ev++;
         end
      end
      prev_bv = byte_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_ev(input int i, input int kind, input int idx, input int val,
                         input int at, input string req);
      if (i >= n_ev) begin
         chk(1'b0, {req, " missing event"}, n_ev, i + 1);
      end else begin
         chk(ev_kind[i] == kind, {req, " kind"}, ev_kind[i], kind);
         if (kind == 1) chk(ev_idx[i] == idx, {req, " index"}, ev_idx[i], idx);
         chk(ev_val[i] == val, {req, " value"}, ev_val[i], val);
         chk(ev_cnt[i] == at, {req, " sample count"}, ev_cnt[i], at);
      end
   endtask

   task automatic clear_stim();
      for (int i = 0; i < 1024; i++) stim[i] = LO_RAW;
   endtask

   task automatic put_start(input int p);
      stim[p]   = HI_RAW; stim[p+1] = HI_RAW; stim[p+2] = LO_RAW;
      stim[p+3] = HI_RAW; stim[p+4] = HI_RAW;
   endtask

   // bit value 0 is sent as high majority, 1 as low majority
   task automatic put_byte(input int p, input logic [7:0] b, input bit solid);
      for (int k = 0; k < 8; k++) begin
         logic [11:0] lv, nl;
         int base;
         lv = b[k] ? LO_RAW : HI_RAW;
         nl = b[k] ? HI_RAW : LO_RAW;
         base = p + toff[k];
         stim[base] = lv; stim[base+1] = lv; stim[base+2] = lv;
         if (!solid) begin
            if (k % 2 == 0) stim[base+2] = nl;
            else            stim[base]   = nl;
         end
      end
   endtask

   task automatic push(input int first, input int last, input bit gaps);
      for (int i = first; i <= last; i++) begin
         @(negedge clk);
         smp_valid = 1'b1; smp_data = stim[i];
         if (gaps) begin
            @(negedge clk);
            smp_valid = 1'b0; smp_data = HI_RAW;
         end
      end
      @(negedge clk);
      smp_valid = 1'b0; smp_data = LO_RAW;
      repeat (3) @(negedge clk);
   endtask

   task automatic start_frame(input bit with_sample);
      @(negedge clk);
      n_ev = 0;
      frame_start = 1'b1; smp_valid = with_sample; smp_data = HI_RAW;
      @(negedge clk);
      frame_start = 1'b0; smp_valid = 1'b0; smp_data = LO_RAW;
   endtask

   task automatic t_reset();
      chk(byte_valid == 1'b0, "R8 reset byte_valid", int'(byte_valid), 0);
      chk(err_valid == 1'b0, "R8 reset err_valid", int'(err_valid), 0);
      chk(byte_data == 8'h00, "R8 reset byte_data", int'(byte_data), 0);
      chk(err_code == 8'h00, "R8 reset err_code", int'(err_code), 0);
   endtask

   // R4 R5 R6 R8, and R10 when gaps are inserted
   task automatic t_basic(input bit gaps);
      int p0, p1;
      p0 = 12; p1 = p0 + 187 + 3;
      start_frame(0);
      clear_stim();
      put_start(p0); put_byte(p0, 8'hC6, 0);
      put_start(p1); put_byte(p1, 8'h39, 0);
      put_start(p1 + 150);
      push(0, p1 + 200, gaps);
      chk(n_ev == 2, gaps ? "R10 event count" : "R8 event count", n_ev, 2);
      chk_ev(0, 1, 0, 8'hC6, p0 + 140, gaps ? "R10 byte0" : "R4 R6 byte0");
      chk_ev(1, 1, 1, 8'h39, p1 + 140, gaps ? "R10 byte1" : "R5 R8 byte1");
   endtask

   // R7: second search starts exactly at offset 187
   task automatic t_gap_edge();
      start_frame(0);
      clear_stim();
      put_start(0); put_byte(0, 8'h81, 0);
      for (int i = 182; i <= 186; i++) stim[i] = HI_RAW;
      put_start(187); put_byte(187, 8'h7E, 0);
      push(0, 187 + 150, 0);
      chk(n_ev == 2, "R7 event count", n_ev, 2);
      chk_ev(1, 1, 1, 8'h7E, 187 + 140, "R7 byte1 after gap");
   endtask

   // R3: timeout on byte 0, frame ends
   task automatic t_err_first();
      start_frame(0);
      clear_stim();
      put_start(420); put_byte(420, 8'h55, 0);
      push(0, 600, 0);
      chk(n_ev == 1, "R3 events after error", n_ev, 1);
      chk_ev(0, 2, 0, 8'h11, 405, "R3 error byte0");
   endtask

   // R3: start at the last allowed window
   task automatic t_limit();
      start_frame(0);
      clear_stim();
      put_start(400); put_byte(400, 8'h5A, 0);
      put_start(587); put_byte(587, 8'h01, 0);
      push(0, 587 + 145, 0);
      chk(n_ev == 2, "R3 limit event count", n_ev, 2);
      chk_ev(0, 1, 0, 8'h5A, 540, "R3 limit byte0");
      chk_ev(1, 1, 1, 8'h01, 727, "R6 limit byte1");
   endtask

   // R3: timeout on byte 1
   task automatic t_err_second();
      start_frame(0);
      clear_stim();
      put_start(5); put_byte(5, 8'h33, 0);
      push(0, 650, 0);
      chk(n_ev == 2, "R3 second error count", n_ev, 2);
      chk_ev(1, 2, 0, 8'h22, 5 + 187 + 405, "R3 error byte1");
   endtask

   // R2: 3-of-5 window passed over; R5 with full triples; R1 boundary levels
   task automatic t_weak_window();
      start_frame(0);
      clear_stim();
      stim[5] = HI_RAW; stim[7] = HI_RAW; stim[9] = HI_RAW;
      put_start(30); put_byte(30, 8'hE1, 1);
      push(0, 30 + 150, 0);
      chk(n_ev == 1, "R2 event count", n_ev, 1);
      chk_ev(0, 1, 0, 8'hE1, 170, "R2 R1 weak window skipped");
   endtask

   // R5: all-zero and all-one bytes
   task automatic t_solid();
      start_frame(0);
      clear_stim();
      put_start(2); put_byte(2, 8'h00, 1);
      put_start(189); put_byte(189, 8'hFF, 1);
      push(0, 189 + 145, 0);
      chk_ev(0, 1, 0, 8'h00, 142, "R5 byte 0x00");
      chk_ev(1, 1, 1, 8'hFF, 329, "R5 byte 0xFF");
   endtask

   // R9: restart mid frame with an ignored sample
   task automatic t_restart();
      start_frame(0);
      clear_stim();
      put_start(3); put_byte(3, 8'hAA, 0);
      push(0, 80, 0);
      start_frame(1);
      clear_stim();
      put_start(0); put_byte(0, 8'h96, 0);
      push(0, 150, 0);
      chk(n_ev == 1, "R9 event count", n_ev, 1);
      chk_ev(0, 1, 0, 8'h96, 140, "R9 restart byte0");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic(0);
      t_basic(1);
      t_gap_edge();
      t_err_first();
      t_limit();
      t_err_second();
      t_weak_window();
      t_solid();
      t_restart();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule